// File: doc/BRIEF.md
# Configurable Audio Frame Serializer

This block is the transmit half of a master-mode audio port. It divides its reference clock into a bit clock and builds a frame sync from that bit clock. It shifts 32-bit sample words onto one serial data line, one slot after another. One engine covers I2S, left- and right-justified, DSP and TDM framing. Seven static fields shape the frame: sync lead, sync width, sync polarity, slot size, slot count, bit order and a per-slot mask. Each count field is stored as its value minus one.

Words come from a show-ahead transmit FIFO. The block pops one word at the start of every slot whose mask bit is clear. A slot whose mask bit is set takes nothing and sends zeros. An unmasked slot that starts while the FIFO is empty sends zeros and raises a one-cycle underrun pulse. All logic runs on the reference clock. The configuration fields are to be changed only while the enable is low.

Top module: `aud_frame_tx`

## Requirements
- R1: While enabled, the bit clock toggles every `cfg_div`+1 reference cycles, so one bit period is 2*(`cfg_div`+1) reference cycles. While disabled, it rests at 1 when `cfg_drive_rise`=0 and at 0 when `cfg_drive_rise`=1.
- R2: With `cfg_drive_rise`=0, data and sync change only on falling bit-clock edges and are sampled on rising edges. With `cfg_drive_rise`=1 the two edges swap roles.
- R3: Let p be the position of a bit period inside the frame, counted 0 to L-1, and let w be `cfg_sync_w`. When `cfg_sync_early`=0, sync is active while p ≤ w. When `cfg_sync_early`=1, sync is active while ((p+1) mod L) ≤ w, so it leads the first data bit by one bit period.
- R4: `cfg_sync_low`=0 makes the active sync level 1. `cfg_sync_low`=1 inverts the sync output.
- R5: A frame holds `cfg_slots`+1 slots of `cfg_slot_bits`+1 bits each, so L is their product. Frames repeat back to back.
- R6: `cfg_lsb_first`=0 sends word bits 31, 30 and so on down to 31-`cfg_slot_bits`. `cfg_lsb_first`=1 sends the same bits in the reverse order, starting at bit 31-`cfg_slot_bits` and ending at bit 31. Samples sit toward bit 31.
- R7: Bit s of `cfg_mask` governs slot s. A clear bit pops exactly one word, with `fifo_pop` high for one cycle, at the drive edge that starts the slot. A set bit pops nothing, and the slot sends zeros.
- R8: An unmasked slot that starts while `fifo_empty` is high pops nothing and sends zeros for the whole slot. `underrun` is high for exactly one reference cycle at its start.
- R9: The first bit period after enable is a lead-in that sits at frame position L-1, sends zero and pops nothing. Frame position 0 follows it. Dropping the enable returns the bit clock to its rest level and drives sync inactive and data 0.
- R10: During reset the bit clock is 1, and sync (before polarity), data, `fifo_pop` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the block idle |
| cfg_div | input | DIV_W | Bit-clock half-period in reference cycles, minus one |
| cfg_drive_rise | input | 1 | 1: drive on the rising bit-clock edge; 0: drive on the falling edge |
| cfg_sync_early | input | 1 | Sync leads frame start by one bit period |
| cfg_sync_low | input | 1 | Sync is active low |
| cfg_sync_w | input | log2(WORD_W) | Sync width in bit periods, minus one |
| cfg_slot_bits | input | log2(WORD_W) | Bits per slot, minus one |
| cfg_slots | input | log2(MAX_SLOTS) | Slots per frame, minus one |
| cfg_lsb_first | input | 1 | Send the least significant sample bit first |
| cfg_mask | input | MAX_SLOTS | Per-slot skip mask (1 = no FIFO read) |
| fifo_empty | input | 1 | Transmit FIFO holds no word |
| fifo_data | input | WORD_W | Head word of the FIFO |
| fifo_pop | output | 1 | Consume the head word this cycle |
| bclk | output | 1 | Bit clock |
| sync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse: an unmasked slot found the FIFO empty |

## Verification
The bench builds the block with its default parameters: an 8-bit divider field, 32-bit words and 16 mask bits. With these, full-width slots, eight-slot TDM frames, the upper mask bits and both bit orders can all be reached. The bench runs with small divider values (0 to 4) to keep runs short, while still covering the no-wait case where the divider is 0. An I2S frame, an eight-slot TDM frame, a masked 16-bit LSB-first frame with an active-low sync driven on the rising edge, and a 24-bit frame that starves the FIFO are each checked bit by bit against a model of frame position.

// File: rtl/aft_pkg.sv
package aft_pkg;
    localparam int DEF_DIV_W     = 8;
    localparam int DEF_WORD_W    = 32;
    localparam int DEF_MAX_SLOTS = 16;

    typedef enum logic {
        ORD_MSB_FIRST = 1'b0,
        ORD_LSB_FIRST = 1'b1
    } bit_order_e;
endpackage

// File: rtl/aft_bitclk.sv
module aft_bitclk #(
    parameter int DIV_W = aft_pkg::DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_drive_rise,
    output logic             bclk,
    output logic             drive_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } bc_t;

    bc_t bc_d, bc_q;
    logic term;

    always_comb begin
        bc_d       = bc_q;
        term       = en && (bc_q.cnt == cfg_div);
        drive_tick = term && (bc_q.lvl == !cfg_drive_rise);
        if (!en) begin
            bc_d.cnt = '0;
            bc_d.lvl = !cfg_drive_rise;
        end else if (term) begin
            bc_d.cnt = '0;
            bc_d.lvl = !bc_q.lvl;
        end else begin
            bc_d.cnt = bc_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q <= '{cnt: '0, lvl: 1'b1};
        end else begin
            bc_q <= bc_d;
        end
    end

    assign bclk = bc_q.lvl;

    // R1: the half-period counter never passes the programmed limit
    p_div_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (bc_q.cnt <= cfg_div));

    // R1: a disabled bit clock rests at the level opposite to the drive edge
    p_rest_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (bclk == !$past(cfg_drive_rise)));
endmodule

// File: rtl/aft_frame_seq.sv
module aft_frame_seq #(
    parameter int WORD_W    = aft_pkg::DEF_WORD_W,
    parameter int MAX_SLOTS = aft_pkg::DEF_MAX_SLOTS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         drive_tick,
    input  logic                         cfg_sync_early,
    input  logic [$clog2(WORD_W)-1:0]    cfg_sync_w,
    input  logic [$clog2(WORD_W)-1:0]    cfg_slot_bits,
    input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots,
    input  logic [MAX_SLOTS-1:0]         cfg_mask,
    input  logic                         fifo_empty,
    output logic                         slot_start,
    output logic                         take_word,
    output logic                         starve,
    output logic [$clog2(WORD_W)-1:0]    bit_nx,
    output logic                         sync_act
);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int SLOT_W = $clog2(MAX_SLOTS);
    localparam int POS_W  = BIT_W + SLOT_W;

    typedef struct packed {
        logic              started;
        logic [POS_W-1:0]  fpos;
        logic [BIT_W-1:0]  bitc;
        logic [SLOT_W-1:0] slot;
        logic              sync;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [POS_W:0]   slots_n, bits_n, frame_len;
    logic [POS_W-1:0] frame_last, lead_pos;
    logic             new_slot;
    logic             want_word;

    always_comb begin
        slots_n    = {{(POS_W+1-SLOT_W){1'b0}}, cfg_slots} + (POS_W+1)'(1);
        bits_n     = {{(POS_W+1-BIT_W){1'b0}}, cfg_slot_bits} + (POS_W+1)'(1);
        frame_len  = slots_n * bits_n;
        frame_last = POS_W'(frame_len - (POS_W+1)'(1));
    end

    always_comb begin
        sq_d     = sq_q;
        new_slot = 1'b0;
        lead_pos = '0;
        if (!en) begin
            sq_d = '0;
        end else if (drive_tick) begin
            if (!sq_q.started) begin
                sq_d.started = 1'b1;
                sq_d.fpos    = frame_last;
                sq_d.bitc    = cfg_slot_bits;
                sq_d.slot    = cfg_slots;
            end else if (sq_q.fpos == frame_last) begin
                sq_d.fpos = '0;
                sq_d.bitc = '0;
                sq_d.slot = '0;
                new_slot  = 1'b1;
            end else begin
                sq_d.fpos = sq_q.fpos + POS_W'(1);
                if (sq_q.bitc == cfg_slot_bits) begin
                    sq_d.bitc = '0;
                    sq_d.slot = sq_q.slot + SLOT_W'(1);
                    new_slot  = 1'b1;
                end else begin
                    sq_d.bitc = sq_q.bitc + BIT_W'(1);
                end
            end
            if (cfg_sync_early) begin
                lead_pos = (sq_d.fpos == frame_last) ? '0 : sq_d.fpos + POS_W'(1);
            end else begin
                lead_pos = sq_d.fpos;
            end
            sq_d.sync = (lead_pos <= {{(POS_W-BIT_W){1'b0}}, cfg_sync_w});
        end
        want_word  = new_slot && !cfg_mask[sq_d.slot];
        slot_start = new_slot;
        take_word  = want_word && !fifo_empty;
        starve     = want_word && fifo_empty;
        bit_nx     = sq_d.bitc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign sync_act = sq_q.sync;

    // R5: the frame position stays inside the programmed frame length
    p_pos_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sq_q.started) |-> (sq_q.fpos <= frame_last));

    // R9: the first bit period after enable sits at the last frame position
    p_lead_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $rose(sq_q.started)) |-> (sq_q.fpos == frame_last));

    // R7: a word is only taken at the first bit of a slot
    p_take_at_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |-> (drive_tick && bit_nx == '0));
endmodule

// File: rtl/aft_shift_out.sv
module aft_shift_out #(
    parameter int WORD_W = aft_pkg::DEF_WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      drive_tick,
    input  logic                      slot_start,
    input  logic                      take_word,
    input  logic                      starve,
    input  logic [$clog2(WORD_W)-1:0] bit_nx,
    input  logic [$clog2(WORD_W)-1:0] cfg_slot_bits,
    input  logic                      cfg_lsb_first,
    input  logic [WORD_W-1:0]         fifo_data,
    output logic                      sdata,
    output logic                      underrun
);
    import aft_pkg::*;

    localparam int BIT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              dout;
        logic              under;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [WORD_W-1:0] word_nx;
    logic [BIT_W-1:0]  pick;
    bit_order_e        order;

    always_comb begin
        order   = bit_order_e'(cfg_lsb_first);
        sh_d    = sh_q;
        word_nx = sh_q.word;
        pick    = '0;
        sh_d.under = 1'b0;
        if (!en) begin
            sh_d.word = '0;
            sh_d.dout = 1'b0;
        end else if (drive_tick) begin
            if (slot_start) begin
                word_nx = take_word ? fifo_data : '0;
            end
            if (order == ORD_LSB_FIRST) begin
                pick = BIT_W'(WORD_W - 1) - cfg_slot_bits + bit_nx;
            end else begin
                pick = BIT_W'(WORD_W - 1) - bit_nx;
            end
            sh_d.word  = word_nx;
            sh_d.dout  = word_nx[pick];
            sh_d.under = starve;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdata    = sh_q.dout;
    assign underrun = sh_q.under;

    // R8: a starved slot sends zero from its first bit
    p_starve_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !sdata);

    // R8: underrun is a single-cycle pulse
    p_under_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);
endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx #(
    parameter int DIV_W     = aft_pkg::DEF_DIV_W,
    parameter int WORD_W    = aft_pkg::DEF_WORD_W,
    parameter int MAX_SLOTS = aft_pkg::DEF_MAX_SLOTS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic [DIV_W-1:0]             cfg_div,
    input  logic                         cfg_drive_rise,
    input  logic                         cfg_sync_early,
    input  logic                         cfg_sync_low,
    input  logic [$clog2(WORD_W)-1:0]    cfg_sync_w,
    input  logic [$clog2(WORD_W)-1:0]    cfg_slot_bits,
    input  logic [$clog2(MAX_SLOTS)-1:0] cfg_slots,
    input  logic                         cfg_lsb_first,
    input  logic [MAX_SLOTS-1:0]         cfg_mask,
    input  logic                         fifo_empty,
    input  logic [WORD_W-1:0]            fifo_data,
    output logic                         fifo_pop,
    output logic                         bclk,
    output logic                         sync,
    output logic                         sdata,
    output logic                         underrun
);
    localparam int BIT_W = $clog2(WORD_W);

    logic             drive_tick;
    logic             slot_start;
    logic             take_word;
    logic             starve;
    logic [BIT_W-1:0] bit_nx;
    logic             sync_act;

    aft_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .cfg_div        (cfg_div),
        .cfg_drive_rise (cfg_drive_rise),
        .bclk           (bclk),
        .drive_tick     (drive_tick)
    );

    aft_frame_seq #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .drive_tick     (drive_tick),
        .cfg_sync_early (cfg_sync_early),
        .cfg_sync_w     (cfg_sync_w),
        .cfg_slot_bits  (cfg_slot_bits),
        .cfg_slots      (cfg_slots),
        .cfg_mask       (cfg_mask),
        .fifo_empty     (fifo_empty),
        .slot_start     (slot_start),
        .take_word      (take_word),
        .starve         (starve),
        .bit_nx         (bit_nx),
        .sync_act       (sync_act)
    );

    aft_shift_out #(.WORD_W(WORD_W)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .drive_tick    (drive_tick),
        .slot_start    (slot_start),
        .take_word     (take_word),
        .starve        (starve),
        .bit_nx        (bit_nx),
        .cfg_slot_bits (cfg_slot_bits),
        .cfg_lsb_first (cfg_lsb_first),
        .fifo_data     (fifo_data),
        .sdata         (sdata),
        .underrun      (underrun)
    );

    assign fifo_pop = take_word;
    assign sync     = sync_act ^ cfg_sync_low;

    // R2: serial data moves only on a drive edge
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !drive_tick) |=> $stable(sdata));

    // R3: sync moves only on a drive edge
    p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !drive_tick) |=> $stable(sync_act));

    // R7: a pop never happens against an empty FIFO
    p_pop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!fifo_empty && !underrun));
endmodule

// File: tb/aud_frame_tx_bench.sv
`timescale 1ns/1ps
module aud_frame_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  cfg_div = '0;
    logic        cfg_drive_rise = 1'b0;
    logic        cfg_sync_early = 1'b0;
    logic        cfg_sync_low = 1'b0;
    logic [4:0]  cfg_sync_w = '0;
    logic [4:0]  cfg_slot_bits = 5'd31;
    logic [3:0]  cfg_slots = 4'd1;
    logic        cfg_lsb_first = 1'b0;
    logic [15:0] cfg_mask = 16'hFFFC;
    logic        fifo_empty;
    logic [31:0] fifo_data;
    logic        fifo_pop, bclk, sync, sdata, underrun;

    logic [31:0] mem [0:15];
    logic [4:0]  rd_ptr;
    logic [4:0]  wr_cnt = '0;
    logic        q_clr = 1'b0;
    int          under_cnt;
    int          tests = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    aud_frame_tx u_aud_frame_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_div(cfg_div),
        .cfg_drive_rise(cfg_drive_rise), .cfg_sync_early(cfg_sync_early),
        .cfg_sync_low(cfg_sync_low), .cfg_sync_w(cfg_sync_w),
        .cfg_slot_bits(cfg_slot_bits), .cfg_slots(cfg_slots),
        .cfg_lsb_first(cfg_lsb_first), .cfg_mask(cfg_mask),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .bclk(bclk), .sync(sync), .sdata(sdata), .underrun(underrun)
    );

    assign fifo_empty = (rd_ptr == wr_cnt);
    assign fifo_data  = fifo_empty ? 32'h0 : mem[rd_ptr[3:0]];

    always @(posedge clk) begin
        if (q_clr) begin
            rd_ptr    <= '0;
            under_cnt <= 0;
        end else begin
            if (fifo_pop) rd_ptr <= rd_ptr + 5'd1;
            if (underrun) under_cnt <= under_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(bclk == 1'b1, "R10 bclk in reset", bclk, 1);
        chk(sync == 1'b0, "R10 sync in reset", sync, 0);
        chk(sdata == 1'b0, "R10 sdata in reset", sdata, 0);
        chk(fifo_pop == 1'b0, "R10 pop in reset", fifo_pop, 0);
        chk(underrun == 1'b0, "R10 underrun in reset", underrun, 0);
    endtask

    // Runs nframes whole frames plus the lead-in bit and checks every sampled bit.
    task automatic run_case(input string name, input int div, input bit rise,
                            input bit early, input bit low, input int sw,
                            input int ss, input int slots, input logic [15:0] mask,
                            input bit lsb, input int nwords, input int nframes,
                            input logic [31:0] seed);
        int L, nsamp, used, pops_exp, under_exp, bad_sync, bad_data, p, b, s, adj;
        logic [31:0] cur;
        bit es, ed;
        realtime t1, t2;
        @(negedge clk);
        en = 1'b0;
        cfg_div = 8'(div); cfg_drive_rise = rise; cfg_sync_early = early;
        cfg_sync_low = low; cfg_sync_w = 5'(sw); cfg_slot_bits = 5'(ss);
        cfg_slots = 4'(slots); cfg_mask = mask; cfg_lsb_first = lsb;
        for (int i = 0; i < 16; i++) mem[i] = seed ^ (32'(i) * 32'h1F35_A7C9);
        wr_cnt = 5'(nwords);
        q_clr = 1'b1;
        repeat (3) @(negedge clk);
        q_clr = 1'b0;
        en = 1'b1;
        L = (slots + 1) * (ss + 1);
        nsamp = 1 + L * nframes;
        used = 0; pops_exp = 0; under_exp = 0; bad_sync = 0; bad_data = 0;
        cur = '0; t1 = 0; t2 = 0;
        for (int k = 0; k < nsamp; k++) begin
            if (rise) @(negedge bclk); else @(posedge bclk);
            if (k == 1) t1 = $realtime;
            if (k == 2) t2 = $realtime;
            p = (k == 0) ? L - 1 : (k - 1) % L;
            b = p % (ss + 1);
            s = p / (ss + 1);
            if (k > 0 && b == 0) begin
                if (!mask[s]) begin
                    if (used < nwords) begin
                        cur = mem[used];
                        used++;
                        pops_exp++;
                    end else begin
                        cur = '0;
                        under_exp++;
                    end
                end else begin
                    cur = '0;
                end
            end
            ed = lsb ? cur[31 - ss + b] : cur[31 - b];
            adj = early ? ((p == L - 1) ? 0 : p + 1) : p;
            es = (adj <= sw) ^ low;
            if (sync !== es) bad_sync++;
            if (sdata !== ed) begin
                if (bad_data == 0)
                    $display("  %s: first data mismatch at sample %0d", name, k);
                bad_data++;
            end
        end
        @(negedge clk);
        en = 1'b0;
        repeat (4) @(negedge clk);
        chk(bad_sync == 0, {"R3 R4 R2 sync stream ", name}, bad_sync, 0);
        chk(bad_data == 0, {"R5 R6 R7 R2 data stream ", name}, bad_data, 0);
        chk((t2 - t1) == 2.0 * (div + 1) * 5.0, {"R1 bit period ", name},
            longint'(t2 - t1), longint'(2 * (div + 1) * 5));
        chk(int'(rd_ptr) == pops_exp, {"R7 words popped ", name}, rd_ptr, pops_exp);
        chk(under_cnt == under_exp, {"R8 underrun pulses ", name}, under_cnt, under_exp);
        chk(bclk == !rise && sync == low && sdata == 1'b0,
            {"R9 R1 idle after disable ", name},
            {bclk, sync, sdata}, {!rise, low, 1'b0});
    endtask

    task automatic test_i2s();
        run_case("i2s", 1, 1'b0, 1'b1, 1'b0, 31, 31, 1, 16'hFFFC, 1'b0, 4, 2, 32'hC0DE_1234);
    endtask

    task automatic test_tdm();
        run_case("tdm", 0, 1'b0, 1'b0, 1'b0, 0, 31, 7, 16'hFF00, 1'b0, 8, 1, 32'h5A5A_F00F);
    endtask

    task automatic test_masked_lsb();
        run_case("mask_lsb", 2, 1'b1, 1'b0, 1'b1, 3, 15, 3, 16'hFFFA, 1'b1, 4, 2, 32'h8421_7E3C);
    endtask

    task automatic test_starve();
        run_case("starve", 4, 1'b0, 1'b0, 1'b0, 23, 23, 1, 16'hFFFC, 1'b0, 1, 2, 32'hF0E1_D2C3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        q_clr = 1'b1;
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        q_clr = 1'b0;
        test_i2s();
        test_tdm();
        test_masked_lsb();
        test_starve();
        summary();
        $finish;
    end
endmodule